// File: doc/BRIEF.md
# Register-Driven Serial Flash Command Bridge

This block lets software drive a serial NOR flash through three 32-bit registers. A write to the command register opens chip select and sends the command and address bytes. Reads or writes of the data register then move one 32-bit word each over the serial bus while chip select stays low. The transaction stays open until software writes an all-zero command or a new command. Commands that carry no data stream close chip select on their own once their bytes are sent.

A control register holds an abort bit and a two-bit rate code that sets the serial clock divider. Register accesses use a request/ready handshake. Any access to the command or data register that arrives while bits are shifting is held off until the shift is done. This gives software a simple polling model without a separate busy flag.

Top module: `spi_flash_bridge`

## Requirements
- R1: Register map: offset 0 is the command register (opcode in bits 31:24, byte address in bits 23:0), offset 1 is the data register, and offset 2 is control (bit 0 is abort, bits 5:4 are the rate code). Reads return the last accepted value. All three registers reset to zero, with chip select high and the serial clock low.
- R2: The serial bus runs in mode 0 with the most significant bit first. The serial clock idles low, data out changes only while the clock is low, and data in is sampled on the rising edge.
- R3: Opcode 0x03 sends the opcode and three address bytes and keeps chip select low. Each later data-register read clocks 32 bits in. The first byte received lands in bits 7:0 of the returned word.
- R4: Writing the all-zero command raises chip select and produces no serial clock edges.
- R5: Opcode 0x02 sends the opcode, three address bytes and the word already in the data register, all in one selection. Each later data-register write sends 32 more bits in the same selection. On the wire, bits 7:0 of a word go first.
- R6: After PAGE_WORDS words in one program selection, further data writes produce no clock edges and leave the data register unchanged.
- R7: Opcodes 0x06, 0x60, 0xAB and any opcode not otherwise listed send only the opcode byte. Opcode 0x52 sends the opcode and three address bytes. Both kinds then raise chip select without a further access.
- R8: Opcode 0x05 sends only the opcode and keeps chip select low. Each data read returns freshly clocked status bytes, with bit 0 as the busy flag.
- R9: Opcode 0x90 sends the opcode and three address bytes. The next data read returns the first ID byte in bits 7:0 and the second in bits 15:8.
- R10: A command or data access made while bits are shifting is not acknowledged until the shift ends. A data read in a read stream is acknowledged only once its 32 bits are captured.
- R11: A command written while a selection is open raises chip select for at least one cycle before the new opcode starts.
- R12: Setting the abort bit raises chip select and stops the serial clock on the next cycle. While the bit is set, command and data writes are acknowledged with no bus activity and no change to the registers.
- R13: Rate code 2 gives a serial clock of the system clock divided by 2. Code 1 divides by 4, code 3 by 8 and code 0 by 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_req | input | 1 | Register access request, held until ready |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 2 | Register offset |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, valid while ready is high |
| csr_ready | output | 1 | Access accepted this cycle |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A responder model answers read, status and ID streams. Its read bytes depend on the address, so a wrong byte order or a lost bit shows up as a wrong value. The status byte changes between reads, which separates a fresh capture from stale held data. Byte-exact bus traffic is compared for single-byte commands, address commands, a full page program with an overflowing write, and back-to-back commands with no close. These cases tell apart missing auto-close, missing reselection and a broken page limit. The bench also measures chip-select length at all four rate codes and aborts a transfer in mid-flight.

// File: rtl/spi_flash_bridge.sv
module spi_flash_bridge #(
  parameter int PAGE_WORDS = 64,
  parameter int DIV_W      = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_req,
  input  logic        csr_we,
  input  logic [1:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        csr_ready,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int WC_W = $clog2(PAGE_WORDS + 1);

  typedef enum logic [1:0] {S_IDLE, S_OPEN, S_SHIFT} st_t;
  st_t st;

  logic [31:0] cmd_q, hold_q, rx_q;
  logic [63:0] tx_q;
  logic [7:0]  op_q;
  logic [6:0]  nbits;
  logic [DIV_W-1:0] cnt, half;
  logic [WC_W-1:0]  wcnt;
  logic [1:0]  rate;
  logic        ctl_rst, sclk_q, rd_pend, rd_done, close_end;

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  wire is_cmd = csr_addr == 2'd0;
  wire is_dat = csr_addr == 2'd1;
  wire is_ctl = csr_addr == 2'd2;
  wire [7:0] new_op = csr_wdata[31:24];
  wire has_addr  = new_op == 8'h03 || new_op == 8'h02 || new_op == 8'h52 || new_op == 8'h90;
  wire stay_open = new_op == 8'h03 || new_op == 8'h02 || new_op == 8'h05 || new_op == 8'h90;
  wire rd_stream = op_q == 8'h03 || op_q == 8'h05 || op_q == 8'h90;
  wire prog      = op_q == 8'h02;
  wire page_room = wcnt < WC_W'(PAGE_WORDS);

  always_comb
    case (rate)
      2'd2:    half = DIV_W'(1);
      2'd1:    half = DIV_W'(2);
      2'd3:    half = DIV_W'(4);
      default: half = DIV_W'(8);
    endcase

  always_comb begin
    csr_ready = 1'b0;
    if (csr_req) begin
      if (!(is_cmd || is_dat) || ctl_rst) csr_ready = 1'b1;
      else case (st)
        S_IDLE:  csr_ready = 1'b1;
        S_OPEN:  if (is_cmd)      csr_ready = !csr_we;
                 else if (csr_we) csr_ready = 1'b1;
                 else             csr_ready = rd_stream ? rd_done : 1'b1;
        default: csr_ready = 1'b0;
      endcase
    end
  end

  assign csr_rdata = is_cmd ? cmd_q : is_dat ? hold_q :
                     is_ctl ? {26'b0, rate, 3'b0, ctl_rst} : 32'b0;
  assign spi_cs_n  = (st == S_IDLE) || ctl_rst;
  assign spi_sclk  = sclk_q;
  assign spi_mosi  = (st == S_SHIFT) && tx_q[63];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cmd_q <= '0; hold_q <= '0; rx_q <= '0; tx_q <= '0;
      op_q <= '0; nbits <= '0; cnt <= '0; wcnt <= '0; rate <= '0;
      ctl_rst <= 1'b0; sclk_q <= 1'b0; rd_pend <= 1'b0; rd_done <= 1'b0;
      close_end <= 1'b0;
    end else begin
      if (csr_req && csr_we && is_ctl) begin
        ctl_rst <= csr_wdata[0];
        rate    <= csr_wdata[5:4];
      end
      if (ctl_rst) begin
        st <= S_IDLE; sclk_q <= 1'b0; rd_pend <= 1'b0; rd_done <= 1'b0;
      end else case (st)
        S_IDLE:
          if (csr_req && csr_we) begin
            if (is_dat) hold_q <= csr_wdata;
            if (is_cmd) begin
              cmd_q <= csr_wdata;
              if (csr_wdata != 32'b0) begin
                op_q      <= new_op;
                tx_q      <= !has_addr ? {new_op, 56'b0} :
                             {csr_wdata, new_op == 8'h02 ? bswap(hold_q) : 32'b0};
                nbits     <= new_op == 8'h02 ? 7'd64 : has_addr ? 7'd32 : 7'd8;
                close_end <= !stay_open;
                wcnt      <= WC_W'(1);
                cnt       <= '0;
                rd_done   <= 1'b0;
                st        <= S_SHIFT;
              end
            end
          end
        S_OPEN:
          if (csr_req) begin
            if (is_cmd && csr_we) begin
              st <= S_IDLE; rd_done <= 1'b0;
            end else if (is_dat && csr_we) begin
              if (prog && page_room) begin
                hold_q    <= csr_wdata;
                tx_q      <= {bswap(csr_wdata), 32'b0};
                nbits     <= 7'd32;
                wcnt      <= wcnt + 1'b1;
                cnt       <= '0;
                close_end <= 1'b0;
                st        <= S_SHIFT;
              end else if (!prog) hold_q <= csr_wdata;
            end else if (is_dat && rd_stream) begin
              if (rd_done) rd_done <= 1'b0;
              else begin
                tx_q <= '0; nbits <= 7'd32; cnt <= '0;
                close_end <= 1'b0; rd_pend <= 1'b1; st <= S_SHIFT;
              end
            end
          end
        default:
          if (cnt >= half - 1'b1) begin
            cnt <= '0;
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              rx_q   <= {rx_q[30:0], spi_miso};
            end else begin
              sclk_q <= 1'b0;
              tx_q   <= tx_q << 1;
              nbits  <= nbits - 1'b1;
              if (nbits == 7'd1) begin
                st <= close_end ? S_IDLE : S_OPEN;
                if (rd_pend) begin
                  hold_q <= bswap(rx_q); rd_done <= 1'b1; rd_pend <= 1'b0;
                end
              end
            end
          end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  p_clk_low_unselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  p_mosi_steady_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk) && !spi_cs_n) |-> $stable(spi_mosi));
  p_select_edge_clk_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> !spi_sclk);
  p_abort_deselects_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rst |=> (spi_cs_n && !spi_sclk));
  p_full_rate_toggle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT && $past(st == S_SHIFT) && rate == 2'd2 && $past(rate == 2'd2) && !ctl_rst)
    |-> spi_sclk != $past(spi_sclk));
  p_no_ack_while_shifting_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT && !ctl_rst && (is_cmd || is_dat)) |-> !csr_ready);
endmodule

// File: tb/spi_flash_bridge_test.sv
module spi_flash_bridge_test;
  logic clk = 0, rst_n = 0;
  logic csr_req = 0, csr_we = 0;
  logic [1:0] csr_addr = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic csr_ready, spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  always #2 clk = ~clk;

  spi_flash_bridge uut (.clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_ready(csr_ready),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [8:0] exp_q[$];
  logic [7:0] status_byte = 8'h03;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // responder and monitor
  logic [7:0] sb[4];
  logic [7:0] cur_byte;
  int rise_cnt = 0, bits = 0, low_cyc = 0, last_low = 0;
  logic prev_sclk = 0, prev_cs = 1;

  always_comb begin
    logic [7:0] rb;
    logic [23:0] a;
    int j;
    j = rise_cnt / 8;
    a = {sb[1], sb[2], sb[3]};
    rb = 8'h00;
    if (sb[0] == 8'h03 && j >= 4) rb = 8'(a + 24'(j - 4)) ^ 8'h5A;
    else if (sb[0] == 8'h05 && j >= 1) rb = status_byte;
    else if (sb[0] == 8'h90 && j == 4) rb = 8'hEF;
    else if (sb[0] == 8'h90 && j == 5) rb = 8'h17;
    spi_miso = rb[7 - (rise_cnt % 8)];
  end

  always @(negedge clk) begin
    if (!spi_cs_n) low_cyc++;
    if (spi_sclk && !prev_sclk && !spi_cs_n) begin
      cur_byte = {cur_byte[6:0], spi_mosi};
      bits++;
      rise_cnt++;
      if (bits % 8 == 0) begin
        if (bits <= 32) sb[bits/8 - 1] = cur_byte;
        if (exp_q.size() == 0) chk(0, "R2", "unexpected bus byte", {24'b0, cur_byte}, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(e == {1'b0, cur_byte}, "R2", "bus byte", {24'b0, cur_byte}, {23'b0, e});
        end
      end
    end
    if (spi_cs_n && !prev_cs) begin
      chk(bits % 8 == 0, "R2", "whole bytes per selection", bits, 0);
      if (exp_q.size() == 0) chk(0, "R4", "unexpected deselect", 0, 32'h100);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk(e == 9'h100, "R4", "deselect point", {23'b0, e}, 32'h100);
      end
      last_low = low_cyc;
      low_cyc = 0; bits = 0; rise_cnt = 0;
      for (int k = 0; k < 4; k++) sb[k] = 8'h00;
    end
    prev_sclk = spi_sclk;
    prev_cs = spi_cs_n;
  end

  task automatic pb(input logic [7:0] b); exp_q.push_back({1'b0, b}); endtask
  task automatic pend(); exp_q.push_back(9'h100); endtask
  task automatic pword(input logic [31:0] w);
    pb(w[7:0]); pb(w[15:8]); pb(w[23:16]); pb(w[31:24]);
  endtask

  task automatic acc(input logic [1:0] a, input logic w, input logic [31:0] d,
                     output logic [31:0] rd, output int waits);
    @(negedge clk);
    csr_req = 1; csr_we = w; csr_addr = a; csr_wdata = d; waits = 0;
    #1;
    while (!csr_ready) begin @(negedge clk); #1; waits++; end
    rd = csr_rdata;
    @(posedge clk); #1;
    csr_req = 0; csr_we = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (!spi_cs_n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] rdword(input logic [23:0] a);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = 8'(a + 24'(i)) ^ 8'h5A;
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, lastw;
    int w;
    for (int k = 0; k < 4; k++) sb[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(spi_cs_n == 1 && spi_sclk == 0, "R1", "reset bus state", {spi_cs_n, spi_sclk}, 2'b10);
    acc(2, 0, 0, rd, w); chk(rd == 0, "R1", "control reset value", rd, 0);
    acc(0, 0, 0, rd, w); chk(rd == 0, "R1", "command reset value", rd, 0);
    acc(2, 1, 32'h20, rd, w);
    acc(2, 0, 0, rd, w); chk(rd == 32'h20, "R1", "control readback", rd, 32'h20);

    // R7 single-byte and address-only commands, R13 full rate
    pb(8'h06); pend();
    acc(0, 1, 32'h0600_0000, rd, w); settle();
    chk(last_low == 16, "R13", "rate 2 select length", last_low, 16);
    pb(8'h52); pb(8'h12); pb(8'h34); pb(8'h00); pend();
    acc(0, 1, 32'h5212_3400, rd, w); settle();
    chk(spi_cs_n == 1, "R7", "erase auto close", spi_cs_n, 1);
    pb(8'h60); pend(); acc(0, 1, 32'h6000_0000, rd, w); settle();
    pb(8'hAB); pend(); acc(0, 1, 32'hAB00_0000, rd, w); settle();
    acc(0, 0, 0, rd, w); chk(rd == 32'hAB00_0000, "R1", "command readback", rd, 32'hAB00_0000);

    // R3 streaming read, R10 stall, R4 close
    pb(8'h03); pb(8'h00); pb(8'h01); pb(8'h00);
    acc(0, 1, 32'h0300_0100, rd, w);
    for (int k = 0; k < 3; k++) begin
      pword(0);
      acc(1, 0, 0, rd, w);
      chk(rd == rdword(24'h100 + 24'(4*k)), "R3", "stream word", rd, rdword(24'h100 + 24'(4*k)));
      chk(w >= 64, "R10", "read held until captured", w, 64);
    end
    chk(spi_cs_n == 0, "R3", "select held open", spi_cs_n, 0);
    pend();
    acc(0, 1, 32'h0, rd, w); settle();
    chk(spi_cs_n == 1, "R4", "zero command closes", spi_cs_n, 1);

    // R8 status stream, R11 new command while open
    pb(8'h05);
    acc(0, 1, 32'h0500_0000, rd, w);
    pword(0); acc(1, 0, 0, rd, w);
    chk(rd == 32'h0303_0303, "R8", "status busy set", rd, 32'h0303_0303);
    status_byte = 8'h02;
    pword(0); acc(1, 0, 0, rd, w);
    chk(rd == 32'h0202_0202 && rd[0] == 0, "R8", "status busy clear", rd, 32'h0202_0202);
    pend(); pb(8'h90); pb(8'h00); pb(8'h00); pb(8'h00);
    acc(0, 1, 32'h9000_0000, rd, w);
    pword(0); acc(1, 0, 0, rd, w);
    chk(rd == 32'h0000_17EF, "R9", "id low bytes", rd, 32'h0000_17EF);
    pend(); pb(8'h06); pend();
    acc(0, 1, 32'h0600_0000, rd, w); settle();
    chk(spi_cs_n == 1, "R11", "reselect then auto close", spi_cs_n, 1);

    // R5 page program, R6 page limit
    acc(1, 1, 32'hA1B2_C3D4, rd, w);
    chk(spi_cs_n == 1, "R5", "preload no bus activity", spi_cs_n, 1);
    pb(8'h02); pb(8'h00); pb(8'h02); pb(8'h00); pword(32'hA1B2_C3D4);
    acc(0, 1, 32'h0200_0200, rd, w);
    lastw = 0;
    for (int i = 1; i < 64; i++) begin
      lastw = {8'(i), ~8'(i), 8'h3C, 8'(i) + 8'h11};
      pword(lastw);
      acc(1, 1, lastw, rd, w);
    end
    acc(1, 1, 32'hDEAD_BEEF, rd, w);
    repeat (80) @(negedge clk);
    chk(spi_cs_n == 0, "R5", "select held across page", spi_cs_n, 0);
    acc(1, 0, 0, rd, w);
    chk(rd == lastw, "R6", "overflow write dropped", rd, lastw);
    pend(); acc(0, 1, 0, rd, w); settle();

    // R13 other rates
    acc(2, 1, 32'h10, rd, w); pb(8'h06); pend(); acc(0, 1, 32'h0600_0000, rd, w); settle();
    chk(last_low == 32, "R13", "rate 1 select length", last_low, 32);
    acc(2, 1, 32'h30, rd, w); pb(8'h06); pend(); acc(0, 1, 32'h0600_0000, rd, w); settle();
    chk(last_low == 64, "R13", "rate 3 select length", last_low, 64);
    acc(2, 1, 32'h00, rd, w); pb(8'h06); pend(); acc(0, 1, 32'h0600_0000, rd, w); settle();
    chk(last_low == 128, "R13", "rate 0 select length", last_low, 128);

    // R12 abort mid-transfer
    pend();
    acc(0, 1, 32'h0300_0040, rd, w);
    acc(2, 1, 32'h01, rd, w);
    @(negedge clk);
    chk(spi_cs_n == 1 && spi_sclk == 0, "R12", "abort deselects", {spi_cs_n, spi_sclk}, 2'b10);
    acc(0, 1, 32'h0600_0000, rd, w);
    chk(w == 0, "R12", "write acked during abort", w, 0);
    acc(1, 1, 32'h5555_AAAA, rd, w);
    repeat (300) @(negedge clk);
    chk(spi_cs_n == 1, "R12", "no bus activity during abort", spi_cs_n, 1);
    acc(2, 1, 32'h20, rd, w);
    acc(0, 0, 0, rd, w);
    chk(rd == 32'h0300_0040, "R12", "command unchanged by write during abort", rd, 32'h0300_0040);
    acc(1, 0, 0, rd, w);
    chk(rd == lastw, "R12", "data unchanged by write during abort", rd, lastw);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "all expected bus items seen", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule